// File: doc/BRIEF.md
# Self-Stabilizing Periodic Reset Watchdog

This block supervises a processor that restores its own correctness by being reset at regular intervals. The processor's software reaches a chosen code point at least once per period, raises a request there and then waits. The watchdog answers each request with a reset pulse of fixed length. If the processor stops asking, the watchdog acts as a deadline backstop. Once the idle time since the last pulse reaches the configured period plus margin, it issues a reset on its own and counts the event.

The watchdog must not become the weak point of the system. Its elapsed-time counter, pulse counter and state register are all treated as possibly corrupted. An elapsed count beyond the deadline and any state encoding outside the two legal ones both count as an expired deadline. Either case causes a reset and returns the block to a legal state within one cycle. The period and margin are live inputs, and the forced-reset count is the only status output.

Top module: `stab_rst_watchdog`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, proc_rst_o is 0 and forced_cnt_o is 0.
- R2: A request sampled in the idle state starts the reset pulse, so proc_rst_o is high on the following cycle and forced_cnt_o does not change.
- R3: Each reset pulse holds proc_rst_o high for exactly PULSE_LEN consecutive cycles, whether it was requested or forced.
- R4: The elapsed counter is zero on the first idle cycle after a pulse and rises by one per idle cycle. A request in one window therefore does not shorten the next window.
- R5: With no request, the forced pulse begins after exactly period_i + margin_i + 1 idle cycles. The deadline is the edge at which the elapsed count equals the sum.
- R6: forced_cnt_o increments by one for every deadline-triggered or recovery-triggered reset and never for a requested one.
- R7: A request that arrives on the very edge at which the deadline expires is treated as requested: the pulse starts and forced_cnt_o is unchanged.
- R8: A request raised while proc_rst_o is high is ignored: the pulse length, forced_cnt_o and the following window are unaffected.
- R9: If the elapsed count exceeds period_i + margin_i (for example after the limit is lowered during a window), the forced pulse starts on the next cycle.
- R10: State encoding: idle is 2'b01 and pulse is 2'b10. Any other state value causes a forced pulse on the next cycle and increments forced_cnt_o.
- R11: With FORCED_SAT = 0 (the default), forced_cnt_o wraps modulo 2^FW. With FORCED_SAT = 1 it saturates at all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Reset request from the supervised processor |
| period_i | input | CW | Nominal interval between requests, in cycles |
| margin_i | input | CW | Extra cycles tolerated past the period |
| proc_rst_o | output | 1 | Reset pulse to the processor, PULSE_LEN cycles long |
| forced_cnt_o | output | FW | Number of resets the watchdog issued on its own |

## Verification
On every cycle the assertions check several behaviours: a pulse that follows each idle-state request or expired deadline, the exact pulse length, a zero elapsed count when a pulse ends, forced-count changes only after a deadline or recovery event, and recovery from an illegal state word in one cycle. Other behaviours need the bench's scenarios. These are the exact window lengths for each period/margin pair, the tie between a request and the deadline on the same edge, requests ignored during a pulse, a limit lowered beneath a running count, counter wrap, and a state word corrupted on purpose.

// File: rtl/swd_pkg.sv
package swd_pkg;
   // Raw two-bit state word; values other than the two below are illegal.
   typedef logic [1:0] swd_state_t;
   localparam swd_state_t ST_IDLE  = 2'b01;
   localparam swd_state_t ST_PULSE = 2'b10;
endpackage

// File: rtl/swd_elapsed.sv
// Elapsed-time counter: runs while idle, held at zero otherwise.
module swd_elapsed #(
   parameter int CW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          run_i,
   input  logic [CW-1:0] period_i,
   input  logic [CW-1:0] margin_i,
   output logic [CW:0]   elapsed_o,
   output logic          expired_o
);
   localparam int TW = CW + 1;

   logic [TW-1:0] cnt_q;
   logic [TW-1:0] limit;

   // One extra bit keeps the sum exact and the counter able to reach it.
   assign limit = {1'b0, period_i} + {1'b0, margin_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!run_i) begin
         cnt_q <= '0;
      end else if (cnt_q != '1) begin
         cnt_q <= cnt_q + TW'(1);
      end
   end

   // Greater-or-equal: a count beyond the limit is an expired deadline too.
   assign expired_o = (cnt_q >= limit);
   assign elapsed_o = cnt_q;
endmodule

// File: rtl/swd_pulse_fsm.sv
// Two-state controller with pulse timer; illegal words fall into a forced pulse.
module swd_pulse_fsm
   import swd_pkg::*;
#(
   parameter int PULSE_LEN = 4
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       req_i,
   input  logic       expired_i,
   output swd_state_t state_o,
   output logic       idle_o,
   output logic       pulse_o,
   output logic       force_evt_o
);
   localparam int PW = (PULSE_LEN < 2) ? 1 : $clog2(PULSE_LEN);
   localparam logic [PW-1:0] PC_LAST = PW'(PULSE_LEN - 1);

   swd_state_t    state_q, state_d;
   logic [PW-1:0] pc_q, pc_d;
   logic          evt;

   always_comb begin
      state_d = state_q;
      pc_d    = '0;
      evt     = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (req_i) begin
               state_d = ST_PULSE;
            end else if (expired_i) begin
               state_d = ST_PULSE;
               evt     = 1'b1;
            end
         end
         ST_PULSE: begin
            if (pc_q >= PC_LAST) begin
               state_d = ST_IDLE;
            end else begin
               pc_d = pc_q + PW'(1);
            end
         end
         default: begin
            state_d = ST_PULSE;
            evt     = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         pc_q    <= '0;
      end else begin
         state_q <= state_d;
         pc_q    <= pc_d;
      end
   end

   assign state_o     = state_q;
   assign idle_o      = (state_q == ST_IDLE);
   assign pulse_o     = (state_q == ST_PULSE);
   assign force_evt_o = evt;
endmodule

// File: rtl/swd_forced_ctr.sv
// Forced-reset event counter; FORCED_SAT selects saturating or wrapping.
module swd_forced_ctr #(
   parameter int FW         = 4,
   parameter bit FORCED_SAT = 1'b0
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          evt_i,
   output logic [FW-1:0] cnt_o
);
   logic [FW-1:0] cnt_q;

   if (FORCED_SAT) begin : g_sat
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                      cnt_q <= '0;
         else if (evt_i && cnt_q != '1)    cnt_q <= cnt_q + FW'(1);
      end
   end else begin : g_wrap
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      cnt_q <= '0;
         else if (evt_i)   cnt_q <= cnt_q + FW'(1);
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/stab_rst_watchdog.sv
// Top: cooperative periodic reset with a deadline backstop.
module stab_rst_watchdog
   import swd_pkg::*;
#(
   parameter int CW         = 8,
   parameter int FW         = 4,
   parameter int PULSE_LEN  = 4,
   parameter bit FORCED_SAT = 1'b0
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          req_i,
   input  logic [CW-1:0] period_i,
   input  logic [CW-1:0] margin_i,
   output logic          proc_rst_o,
   output logic [FW-1:0] forced_cnt_o
);
   if (CW < 1) begin : g_bad_cw
      $error("stab_rst_watchdog: CW must be at least 1");
   end
   if (FW < 1) begin : g_bad_fw
      $error("stab_rst_watchdog: FW must be at least 1");
   end
   if (PULSE_LEN < 1) begin : g_bad_pl
      $error("stab_rst_watchdog: PULSE_LEN must be at least 1");
   end

   swd_state_t  state_w;
   logic        idle_w;
   logic        pulse_w;
   logic        force_evt_w;
   logic        expired_w;
   logic [CW:0] elapsed_w;

   swd_elapsed #(.CW(CW)) u_elapsed (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (idle_w),
      .period_i  (period_i),
      .margin_i  (margin_i),
      .elapsed_o (elapsed_w),
      .expired_o (expired_w)
   );

   swd_pulse_fsm #(.PULSE_LEN(PULSE_LEN)) u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (req_i),
      .expired_i   (expired_w),
      .state_o     (state_w),
      .idle_o      (idle_w),
      .pulse_o     (pulse_w),
      .force_evt_o (force_evt_w)
   );

   swd_forced_ctr #(.FW(FW), .FORCED_SAT(FORCED_SAT)) u_forced (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (force_evt_w),
      .cnt_o  (forced_cnt_o)
   );

   assign proc_rst_o = pulse_w;
endmodule

// File: rtl/stab_rst_watchdog_chk.sv
// Property checker, bound into every stab_rst_watchdog instance.
module stab_rst_watchdog_chk
   import swd_pkg::*;
#(
   parameter int CW        = 8,
   parameter int FW        = 4,
   parameter int PULSE_LEN = 4
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          req_i,
   input logic          proc_rst_o,
   input logic [FW-1:0] forced_cnt_o,
   input swd_state_t    state,
   input logic [CW:0]   elapsed,
   input logic          expired,
   input logic          force_evt
);
   localparam int RW = $clog2(PULSE_LEN + 2);
   localparam logic [RW-1:0] RUN_LAST = RW'(PULSE_LEN - 1);

   // Cycles of the current pulse already seen, counted independently.
   logic [RW-1:0] run_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         run_q <= '0;
      else if (proc_rst_o) run_q <= run_q + RW'(1);
      else                 run_q <= '0;
   end

   AST_REQ_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state == ST_IDLE && req_i) |=> (proc_rst_o && $stable(forced_cnt_o))); // R2

   AST_PULSE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (proc_rst_o && run_q == RUN_LAST) |=> !proc_rst_o); // R3

   AST_PULSE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(proc_rst_o) |-> ($past(run_q) == RUN_LAST)); // R3

   AST_ELAPSED_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(proc_rst_o) |-> (elapsed == '0)); // R4

   AST_DEADLINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state == ST_IDLE && !req_i && expired) |=> proc_rst_o); // R5

   AST_FORCED_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(forced_cnt_o) |-> $past(force_evt)); // R6

   AST_ILLEGAL_RECOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state != ST_IDLE && state != ST_PULSE) |=> (state == ST_PULSE)); // R10
endmodule

bind stab_rst_watchdog stab_rst_watchdog_chk #(
   .CW(CW), .FW(FW), .PULSE_LEN(PULSE_LEN)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .req_i        (req_i),
   .proc_rst_o   (proc_rst_o),
   .forced_cnt_o (forced_cnt_o),
   .state        (state_w),
   .elapsed      (elapsed_w),
   .expired      (expired_w),
   .force_evt    (force_evt_w)
);

// File: tb/sim_stab_rst_watchdog.sv
`timescale 1ns/1ps
module sim_stab_rst_watchdog;
   localparam int CW = 8;
   localparam int FW = 4;
   localparam int PL = 4;

   logic          clk = 1'b0;
   logic          rst_ni = 1'b0;
   logic          req_i = 1'b0;
   logic [CW-1:0] period_i = '0;
   logic [CW-1:0] margin_i = '0;
   logic          proc_rst_o;
   logic [FW-1:0] forced_cnt_o;

   int n_chk = 0;
   int n_bad = 0;
   int exp_forced = 0;
   bit done = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   stab_rst_watchdog #(.CW(CW), .FW(FW), .PULSE_LEN(PL), .FORCED_SAT(1'b0)) u0 (
      .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .period_i(period_i),
      .margin_i(margin_i), .proc_rst_o(proc_rst_o), .forced_cnt_o(forced_cnt_o)
   );

   // Each entry: {period, margin, request sample index (0 = none), request during pulse}
   localparam logic [31:0] VEC [9] = '{
      {8'd5,   8'd2,   8'd0, 8'd0},  // R5 deadline
      {8'd5,   8'd2,   8'd3, 8'd0},  // R2 early request
      {8'd5,   8'd2,   8'd8, 8'd0},  // R7 request on the deadline edge
      {8'd10,  8'd0,   8'd1, 8'd0},  // R2 request on first idle cycle
      {8'd3,   8'd1,   8'd0, 8'd1},  // R8 request held during pulse
      {8'd3,   8'd1,   8'd0, 8'd0},  // R4 full window after that
      {8'd0,   8'd0,   8'd0, 8'd0},  // R5 zero limit
      {8'd255, 8'd255, 8'd0, 8'd0},  // R5 largest limit
      {8'd1,   8'd0,   8'd2, 8'd0}   // R7 tie at small limit
   };

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // Starts on the first idle sample of a window, ends on the first idle sample of the next.
   task automatic window(input int per, input int mar, input int ra, input bit rip);
      int idle = 0;
      int hi = 0;
      int exp_idle;
      period_i = per[CW-1:0];
      margin_i = mar[CW-1:0];
      exp_idle = (ra != 0) ? ra : per + mar + 1;
      while (proc_rst_o == 1'b0 && idle < 2000) begin
         idle++;
         req_i = (idle == ra);
         @(negedge clk);
      end
      req_i = 1'b0;
      if (ra == 0) exp_forced++;
      check(idle == exp_idle,
            (ra == per + mar + 1) ? "R7 tie length" :
            (ra != 0) ? "R2 idle cycles before requested pulse" :
            "R4/R5 idle cycles before forced pulse", idle, exp_idle);
      check(int'(forced_cnt_o) == exp_forced % (1 << FW),
            (ra != 0) ? "R6/R7 forced count unchanged by request" :
            "R6 forced count after deadline", int'(forced_cnt_o), exp_forced % (1 << FW));
      while (proc_rst_o == 1'b1 && hi < 1000) begin
         hi++;
         req_i = rip;
         @(negedge clk);
      end
      req_i = 1'b0;
      check(hi == PL, rip ? "R8 pulse length with request during pulse" : "R3 pulse length",
            hi, PL);
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
   end

   initial begin
      int base;
      int hi;
      period_i = 8'd5;
      margin_i = 8'd2;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(proc_rst_o == 1'b0, "R1 proc_rst_o in reset", proc_rst_o, 0);
      check(forced_cnt_o == '0, "R1 forced_cnt_o in reset", forced_cnt_o, 0);
      rst_ni = 1'b1;

      for (int i = 0; i < 9; i++) begin
         window(int'(VEC[i][31:24]), int'(VEC[i][23:16]), int'(VEC[i][15:8]), VEC[i][0]);
      end

      // R9: limit lowered below a running count
      begin
         int idle = 0;
         period_i = 8'd20;
         margin_i = 8'd0;
         while (proc_rst_o == 1'b0 && idle < 100) begin
            idle++;
            if (idle == 6) begin
               period_i = 8'd2;
               margin_i = 8'd1;
            end
            @(negedge clk);
         end
         exp_forced++;
         check(idle == 6, "R9 expiry after limit lowered", idle, 6);
         check(int'(forced_cnt_o) == exp_forced % (1 << FW), "R9 forced count",
               int'(forced_cnt_o), exp_forced % (1 << FW));
         hi = 0;
         while (proc_rst_o == 1'b1 && hi < 100) begin hi++; @(negedge clk); end
         check(hi == PL, "R9 pulse length", hi, PL);
      end

      // R10: corrupt the state word to 2'b11 during idle
      period_i = 8'd50;
      margin_i = 8'd0;
      force u0.u_fsm.state_q = 2'b11;
      #1 release u0.u_fsm.state_q;
      @(negedge clk);
      exp_forced++;
      check(proc_rst_o == 1'b1, "R10 pulse after illegal state", proc_rst_o, 1);
      check(int'(forced_cnt_o) == exp_forced % (1 << FW), "R10 forced count",
            int'(forced_cnt_o), exp_forced % (1 << FW));
      hi = 0;
      while (proc_rst_o == 1'b1 && hi < 100) begin hi++; @(negedge clk); end
      check(hi == PL, "R10 pulse length after recovery", hi, PL);
      window(3, 0, 0, 1'b0);

      // R11: sixteen forced resets bring the counter back to its start value
      base = int'(forced_cnt_o);
      for (int k = 0; k < (1 << FW); k++) begin
         window(1, 0, 0, 1'b0);
      end
      check(int'(forced_cnt_o) == base, "R11 forced count wraps", int'(forced_cnt_o), base);

      // R1: reset in mid-run clears the status
      rst_ni = 1'b0;
      @(negedge clk);
      check(forced_cnt_o == '0, "R1 forced_cnt_o after late reset", forced_cnt_o, 0);
      check(proc_rst_o == 1'b0, "R1 proc_rst_o after late reset", proc_rst_o, 0);
      rst_ni = 1'b1;
      @(negedge clk);
      check(proc_rst_o == 1'b0 && forced_cnt_o == '0, "R1 first cycle after reset",
            {proc_rst_o, forced_cnt_o}, 0);
      finish_run();
   end
endmodule